// File: doc/BRIEF.md
# Processor Clock-State Power Controller

This block follows the clock-control power state of a processor core. It watches a stop-clock request, a sleep request, a halt-completed pulse, the stop-grant acknowledge flag, snoop start and end strobes, wake-up event inputs and a bus-clock-present indicator. From these it decides whether the core clock may run. It reports the current state as a 3-bit code, drives a core-clock enable, and holds wake-up events that arrive while the core is stopped. Those events are handed out once the core is running again.

A strap input is sampled while reset is active. It picks which of two mutually exclusive stop states the stop-clock request leads to. The first is a stop-grant state, which can go on to sleep and deep sleep. The second is a quick-start state, which can go straight to deep sleep. A shared snoop state goes back to the state it was entered from.

Deep sleep is entered and left by the bus clock itself disappearing and coming back, not by a request. The bus-clock-present input passes through a synchronizer. The wait for the clock generator to lock, and the stop-state exit latencies, are modelled with a shared down-counter.

Top module: `cks_ctrl`

## Requirements
- R1: The state code is Normal=0, Auto Halt=1, Stop Grant=2, Quick Start=3, Halt/Grant Snoop=4, Sleep=5, Deep Sleep=6, and code 7 never appears. Synchronous reset (rst_n low) with stop_req low leaves the block in Normal with core_clk_en high and evt_pend zero.
- R2: When grant_mode_strap is 1 during reset, the stop state is Stop Grant. When it is 0 during reset, the stop state is Quick Start. Only the selected stop state is ever entered.
- R3: Normal goes to Auto Halt on halt_done. Auto Halt goes back to Normal when any of evt_in[4:0], misc_brk or bus_init_brk is high.
- R4: From Normal or Auto Halt, stop_req and grant_ack high together in one cycle move the block to the stop state. stop_req alone does not. Dropping stop_req returns the block to Auto Halt if it was halted, and to Normal otherwise.
- R5: In Stop Grant, bus_init_brk moves the block to Normal even while stop_req is still high.
- R6: snoop_begin in Auto Halt, Stop Grant or Quick Start moves the block to Halt/Grant Snoop. snoop_end then returns it to the state it came from.
- R7: Sleep is entered only from Stop Grant while sleep_req is high. sleep_req has no effect in Normal or Auto Halt. Dropping sleep_req in Sleep returns the block to Stop Grant.
- R8: In Sleep or Quick Start, a low bclk_present seen after a two-stage synchronizer moves the block to Deep Sleep. Once the synchronized clock is present again for LOCK_CYC cycles, the block goes to Quick Start in quick-start mode and to Sleep otherwise.
- R9: In Stop Grant, a high evt_in bit (bit 0 flush, 1 system-management, 2 init, 3 maskable interrupt, 4 non-maskable interrupt) is held, at most once per bit. Held bits appear on evt_pend for exactly one cycle, the first cycle in which core_clk_en is high. Nothing is captured in Quick Start, Sleep or Deep Sleep.
- R10: core_clk_en is high only in Normal. After entering Normal from Stop Grant it rises SG_EXIT_CYC cycles later, and after entering Normal from Quick Start it rises QS_EXIT_CYC cycles later.
- R11: Reset with stop_req high places the block in the selected stop state, and it stays there until stop_req is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| grant_mode_strap | input | 1 | Sampled in reset: 1 selects Stop Grant, 0 selects Quick Start |
| stop_req | input | 1 | Stop-clock request |
| sleep_req | input | 1 | Sleep request |
| halt_done | input | 1 | Halt instruction and its bus cycle completed |
| grant_ack | input | 1 | Stop-grant acknowledge cycle issued |
| snoop_begin | input | 1 | Snoop starts |
| snoop_end | input | 1 | Snoop serviced |
| evt_in | input | 5 | Wake-up events: flush, system-management, init, interrupt, NMI |
| misc_brk | input | 1 | Other halt-break events |
| bus_init_brk | input | 1 | Bus-initialize event, breaks halt and stop grant |
| bclk_present | input | 1 | Bus clock running, asynchronous |
| state_code | output | 3 | Current state code |
| core_clk_en | output | 1 | Core clock enable |
| evt_pend | output | 5 | Held events released for service, one-cycle pulse |

## Verification
The bench builds the block with LOCK_CYC set to 20, and keeps the exit latencies at 10 and 8. This keeps the deep-sleep lock wait short enough to cover several times per run, including a clock dropout in the middle of the lock wait that restarts the count. With these values, both strap settings can be run in one pass by resetting between them. This reaches Stop Grant, Sleep and Deep Sleep in one mode, and Quick Start with Deep Sleep in the other, and the exit latencies are counted cycle by cycle against a behavioural model.

// File: rtl/cks_pkg.sv
package cks_pkg;
    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_HALT   = 3'd1,
        ST_GRANT  = 3'd2,
        ST_QSTART = 3'd3,
        ST_SNOOP  = 3'd4,
        ST_SLEEP  = 3'd5,
        ST_DEEP   = 3'd6
    } cks_state_e;

    localparam int EVT_W = 5;
endpackage

// File: rtl/cks_sync.sv
module cks_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (!rst_n) sh <= {STAGES{RST_VAL}};
        else        sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/cks_delay_cnt.sv
module cks_delay_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         cnt_zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (load)             cnt <= load_val;
        else if (dec && cnt != '0) cnt <= cnt - 1'b1;
    end

    assign cnt_zero = (cnt == '0);
endmodule

// File: rtl/cks_evt_hold.sv
module cks_evt_hold #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic         release_i,
    input  logic [N-1:0] evt_in,
    output logic [N-1:0] pend
);
    logic [N-1:0] held;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)                     held[i] <= 1'b0;
            else if (capture && evt_in[i])  held[i] <= 1'b1;
            else if (release_i)             held[i] <= 1'b0;
        end
        assign pend[i] = release_i & held[i];
    end
endmodule

// File: rtl/cks_ctrl.sv
module cks_ctrl
    import cks_pkg::*;
#(
    parameter int SG_EXIT_CYC = 10,
    parameter int QS_EXIT_CYC = 8,
    parameter int LOCK_CYC    = 3750,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grant_mode_strap,
    input  logic             stop_req,
    input  logic             sleep_req,
    input  logic             halt_done,
    input  logic             grant_ack,
    input  logic             snoop_begin,
    input  logic             snoop_end,
    input  logic [EVT_W-1:0] evt_in,
    input  logic             misc_brk,
    input  logic             bus_init_brk,
    input  logic             bclk_present,
    output logic [2:0]       state_code,
    output logic             core_clk_en,
    output logic [EVT_W-1:0] evt_pend
);
    localparam int MAX_A = (SG_EXIT_CYC > QS_EXIT_CYC) ? SG_EXIT_CYC : QS_EXIT_CYC;
    localparam int MAX_C = (LOCK_CYC > MAX_A) ? LOCK_CYC : MAX_A;
    localparam int CW    = $clog2(MAX_C + 1);

    cks_state_e state, nxt, snp_ret, ret_nxt, rst_state, stop_tgt;
    logic       halt_flag, halt_nxt;
    logic       qs_mode;
    logic       bclk_s;
    logic       cnt_ld, cnt_dec, cnt_zero;
    logic [CW-1:0] cnt_val;
    logic       any_halt_brk;

    cks_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bclk_present),
        .q     (bclk_s)
    );

    cks_delay_cnt #(.W(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_ld),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .cnt_zero (cnt_zero)
    );

    cks_evt_hold #(.N(EVT_W)) u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (state == ST_GRANT),
        .release_i (core_clk_en),
        .evt_in    (evt_in),
        .pend      (evt_pend)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) qs_mode <= ~grant_mode_strap;
    end

    assign stop_tgt     = qs_mode ? ST_QSTART : ST_GRANT;
    assign rst_state    = stop_req ? (grant_mode_strap ? ST_GRANT : ST_QSTART) : ST_RUN;
    assign any_halt_brk = (|evt_in) | misc_brk | bus_init_brk;
    assign cnt_dec      = (state == ST_RUN) || (state == ST_DEEP && bclk_s);

    always_comb begin
        nxt      = state;
        ret_nxt  = snp_ret;
        halt_nxt = halt_flag;
        cnt_ld   = 1'b0;
        cnt_val  = '0;
        unique case (state)
            ST_RUN: begin
                if (cnt_zero) begin
                    if (stop_req && grant_ack) begin
                        nxt = stop_tgt;
                    end else if (halt_done) begin
                        nxt      = ST_HALT;
                        halt_nxt = 1'b1;
                    end
                end
            end
            ST_HALT: begin
                if (stop_req && grant_ack) begin
                    nxt = stop_tgt;
                end else if (snoop_begin) begin
                    nxt     = ST_SNOOP;
                    ret_nxt = ST_HALT;
                end else if (any_halt_brk) begin
                    nxt      = ST_RUN;
                    halt_nxt = 1'b0;
                end
            end
            ST_GRANT: begin
                if (bus_init_brk) begin
                    nxt      = ST_RUN;
                    halt_nxt = 1'b0;
                    cnt_ld   = 1'b1;
                    cnt_val  = CW'(SG_EXIT_CYC);
                end else if (!stop_req) begin
                    if (halt_flag) begin
                        nxt = ST_HALT;
                    end else begin
                        nxt     = ST_RUN;
                        cnt_ld  = 1'b1;
                        cnt_val = CW'(SG_EXIT_CYC);
                    end
                end else if (snoop_begin) begin
                    nxt     = ST_SNOOP;
                    ret_nxt = ST_GRANT;
                end else if (sleep_req) begin
                    nxt = ST_SLEEP;
                end
            end
            ST_QSTART: begin
                if (!stop_req) begin
                    if (halt_flag) begin
                        nxt = ST_HALT;
                    end else begin
                        nxt     = ST_RUN;
                        cnt_ld  = 1'b1;
                        cnt_val = CW'(QS_EXIT_CYC);
                    end
                end else if (snoop_begin) begin
                    nxt     = ST_SNOOP;
                    ret_nxt = ST_QSTART;
                end else if (!bclk_s) begin
                    nxt     = ST_DEEP;
                    cnt_ld  = 1'b1;
                    cnt_val = CW'(LOCK_CYC);
                end
            end
            ST_SNOOP: begin
                if (snoop_end) nxt = snp_ret;
            end
            ST_SLEEP: begin
                if (!sleep_req) begin
                    nxt = ST_GRANT;
                end else if (!bclk_s) begin
                    nxt     = ST_DEEP;
                    cnt_ld  = 1'b1;
                    cnt_val = CW'(LOCK_CYC);
                end
            end
            ST_DEEP: begin
                if (!bclk_s) begin
                    cnt_ld  = 1'b1;
                    cnt_val = CW'(LOCK_CYC);
                end else if (cnt_zero) begin
                    nxt = qs_mode ? ST_QSTART : ST_SLEEP;
                end
            end
            default: nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= rst_state;
            snp_ret   <= ST_RUN;
            halt_flag <= 1'b0;
        end else begin
            state     <= nxt;
            snp_ret   <= ret_nxt;
            halt_flag <= halt_nxt;
        end
    end

    always_comb begin
        state_code  = state;
        core_clk_en = (state == ST_RUN) && cnt_zero;
    end
endmodule

// File: rtl/cks_ctrl_chk.sv
module cks_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       grant_mode_strap,
    input logic       sleep_req,
    input logic [2:0] state_code,
    input logic       core_clk_en,
    input logic [4:0] evt_pend
);
    logic mode_q;

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= grant_mode_strap;
    end

    AST_CODE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        state_code != 3'd7); // R1

    AST_GRANT_MODE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd2) |-> mode_q); // R2

    AST_QSTART_MODE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd3) |-> !mode_q); // R2

    AST_SNOOP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd4 && $past(state_code) != 3'd4) |->
        ($past(state_code) == 3'd1 || $past(state_code) == 3'd2 || $past(state_code) == 3'd3)); // R6

    AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd5 && $past(state_code) != 3'd5) |->
        ($past(state_code) == 3'd2 || $past(state_code) == 3'd6)); // R7

    AST_SLEEP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd5 && $past(state_code) == 3'd2) |-> $past(sleep_req)); // R7

    AST_DEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd6 && $past(state_code) != 3'd6) |->
        ($past(state_code) == 3'd5 || $past(state_code) == 3'd3)); // R8

    AST_PEND_WHEN_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pend != 5'd0) |-> core_clk_en); // R9

    AST_PEND_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pend != 5'd0) |=> (evt_pend == 5'd0)); // R9

    AST_CLKEN_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        core_clk_en |-> (state_code == 3'd0)); // R10
endmodule

bind cks_ctrl cks_ctrl_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .grant_mode_strap (grant_mode_strap),
    .sleep_req        (sleep_req),
    .state_code       (state_code),
    .core_clk_en      (core_clk_en),
    .evt_pend         (evt_pend)
);

// File: tb/sim_cks_ctrl.sv
module sim_cks_ctrl;
    localparam int SGX  = 10;
    localparam int QSX  = 8;
    localparam int LOCK = 20;

    logic       clk = 1'b0;
    logic       rst_n, strap, stop_req, sleep_req, halt_done, grant_ack;
    logic       snoop_begin, snoop_end, misc_brk, bus_init_brk, bclk_present;
    logic [4:0] evt_in;
    logic [2:0] state_code;
    logic       core_clk_en;
    logic [4:0] evt_pend;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string cur_req = "R1";

    // behavioural reference model
    int m_st, m_cnt, m_halt, m_ret, m_qs;
    bit [4:0] m_held;
    bit m_s1, m_s2;

    always #4 clk = ~clk;

    cks_ctrl #(.SG_EXIT_CYC(SGX), .QS_EXIT_CYC(QSX), .LOCK_CYC(LOCK), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .grant_mode_strap(strap), .stop_req(stop_req),
        .sleep_req(sleep_req), .halt_done(halt_done), .grant_ack(grant_ack),
        .snoop_begin(snoop_begin), .snoop_end(snoop_end), .evt_in(evt_in),
        .misc_brk(misc_brk), .bus_init_brk(bus_init_brk), .bclk_present(bclk_present),
        .state_code(state_code), .core_clk_en(core_clk_en), .evt_pend(evt_pend)
    );

    function automatic bit exp_en();
        return (m_st == 0) && (m_cnt == 0);
    endfunction

    task automatic model_step();
        int n_st, n_cnt, n_halt, n_ret;
        bit brk, ld, en;
        if (!rst_n) begin
            m_st = stop_req ? (strap ? 2 : 3) : 0;
            m_cnt = 0; m_halt = 0; m_ret = 0; m_held = '0;
            m_s1 = 1; m_s2 = 1; m_qs = strap ? 0 : 1;
            return;
        end
        en = exp_en();
        n_st = m_st; n_halt = m_halt; n_ret = m_ret; n_cnt = m_cnt; ld = 0;
        brk = (evt_in != 0) || misc_brk || bus_init_brk;
        case (m_st)
            0: if (m_cnt == 0) begin
                   if (stop_req && grant_ack) n_st = m_qs ? 3 : 2;
                   else if (halt_done) begin n_st = 1; n_halt = 1; end
               end
            1: if (stop_req && grant_ack) n_st = m_qs ? 3 : 2;
               else if (snoop_begin) begin n_st = 4; n_ret = 1; end
               else if (brk) begin n_st = 0; n_halt = 0; end
            2: if (bus_init_brk) begin n_st = 0; n_halt = 0; n_cnt = SGX; ld = 1; end
               else if (!stop_req) begin
                   if (m_halt != 0) n_st = 1;
                   else begin n_st = 0; n_cnt = SGX; ld = 1; end
               end
               else if (snoop_begin) begin n_st = 4; n_ret = 2; end
               else if (sleep_req) n_st = 5;
            3: if (!stop_req) begin
                   if (m_halt != 0) n_st = 1;
                   else begin n_st = 0; n_cnt = QSX; ld = 1; end
               end
               else if (snoop_begin) begin n_st = 4; n_ret = 3; end
               else if (!m_s2) begin n_st = 6; n_cnt = LOCK; ld = 1; end
            4: if (snoop_end) n_st = m_ret;
            5: if (!sleep_req) n_st = 2;
               else if (!m_s2) begin n_st = 6; n_cnt = LOCK; ld = 1; end
            6: if (!m_s2) begin n_cnt = LOCK; ld = 1; end
               else if (m_cnt == 0) n_st = m_qs ? 3 : 5;
            default: n_st = 0;
        endcase
        if (!ld && m_cnt > 0 && (m_st == 0 || (m_st == 6 && m_s2))) n_cnt = m_cnt - 1;
        if (m_st == 2) m_held = m_held | evt_in;
        else if (en) m_held = '0;
        m_s2 = m_s1; m_s1 = bclk_present;
        m_st = n_st; m_cnt = n_cnt; m_halt = n_halt; m_ret = n_ret;
    endtask

    task automatic compare();
        bit [4:0] ep;
        ep = exp_en() ? m_held : 5'd0;
        checks++;
        if (state_code !== 3'(m_st)) begin
            errors++;
            $display("FAIL %s state_code actual %0d expected %0d at %0t", cur_req, state_code, m_st, $time);
        end
        checks++;
        if (core_clk_en !== exp_en()) begin
            errors++;
            $display("FAIL %s core_clk_en actual %0b expected %0b at %0t", cur_req, core_clk_en, exp_en(), $time);
        end
        checks++;
        if (evt_pend !== ep) begin
            errors++;
            $display("FAIL %s evt_pend actual %b expected %b at %0t", cur_req, evt_pend, ep, $time);
        end
    endtask

    task automatic cyc(int n = 1);
        for (int i = 0; i < n; i++) begin
            model_step();
            @(posedge clk);
            @(negedge clk);
            compare();
        end
    endtask

    task automatic pulse_clear();
        halt_done = 0; grant_ack = 0; snoop_begin = 0; snoop_end = 0;
        evt_in = '0; misc_brk = 0; bus_init_brk = 0;
    endtask

    task automatic expect_state(int code, string tag);
        checks++;
        if (state_code !== 3'(code)) begin
            errors++;
            $display("FAIL %s directed state actual %0d expected %0d", tag, state_code, code);
        end
    endtask

    task automatic do_reset(bit s, bit sreq);
        rst_n = 0; strap = s; stop_req = sreq; sleep_req = 0; bclk_present = 1;
        pulse_clear();
        cyc(3);
        rst_n = 1;
        cyc(3);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset into Normal
        cur_req = "R1";
        do_reset(1'b1, 1'b0);
        expect_state(0, "R1");

        // R3: halt and break by interrupt, then by misc break
        cur_req = "R3";
        halt_done = 1; cyc(); pulse_clear(); cyc(2);
        expect_state(1, "R3");
        evt_in = 5'b01000; cyc(); pulse_clear(); cyc(2);
        expect_state(0, "R3");
        halt_done = 1; cyc(); pulse_clear(); cyc();
        misc_brk = 1; cyc(); pulse_clear(); cyc();

        // R4: stop request needs acknowledge; release to Normal
        cur_req = "R4";
        stop_req = 1; cyc(3);
        expect_state(0, "R4");
        grant_ack = 1; cyc(); pulse_clear(); cyc(2);
        expect_state(2, "R4");
        // R7: sleep, ignored elsewhere; R6 snoop in stop grant
        cur_req = "R6";
        snoop_begin = 1; cyc(); pulse_clear(); cyc(2);
        expect_state(4, "R6");
        snoop_end = 1; cyc(); pulse_clear(); cyc();
        expect_state(2, "R6");
        // R9: capture events
        cur_req = "R9";
        evt_in = 5'b00001; cyc(); evt_in = 5'b01001; cyc(); pulse_clear(); cyc();
        // R10: exit latency from stop grant
        cur_req = "R10";
        stop_req = 0; cyc(SGX + 4);
        expect_state(0, "R10");

        // R7: sleep request ignored in Normal and Auto Halt
        cur_req = "R7";
        sleep_req = 1; cyc(3);
        halt_done = 1; cyc(); pulse_clear(); cyc(3);
        expect_state(1, "R7");
        // R4: halted, stop, release back to Auto Halt; sleep on the way
        cur_req = "R4";
        sleep_req = 0; stop_req = 1; grant_ack = 1; cyc(); pulse_clear(); cyc();
        cur_req = "R7";
        sleep_req = 1; cyc(2);
        expect_state(5, "R7");
        sleep_req = 0; cyc(2);
        expect_state(2, "R7");
        cur_req = "R4";
        stop_req = 0; cyc(2);
        expect_state(1, "R4");
        // R6: snoop in Auto Halt
        cur_req = "R6";
        snoop_begin = 1; cyc(); pulse_clear(); cyc();
        snoop_end = 1; cyc(); pulse_clear(); cyc();
        expect_state(1, "R6");
        evt_in = 5'b10000; cyc(); pulse_clear(); cyc(2);

        // R5: bus init breaks stop grant
        cur_req = "R5";
        stop_req = 1; grant_ack = 1; cyc(); pulse_clear(); cyc();
        evt_in = 5'b00110; cyc(); pulse_clear();
        bus_init_brk = 1; cyc(); pulse_clear(); cyc(SGX + 3);
        expect_state(0, "R5");

        // R8: deep sleep through sleep in stop-grant mode, with a dropout
        cur_req = "R8";
        grant_ack = 1; cyc(); pulse_clear(); sleep_req = 1; cyc(2);
        bclk_present = 0; cyc(6);
        expect_state(6, "R8");
        bclk_present = 1; cyc(8);
        bclk_present = 0; cyc(3);
        bclk_present = 1; cyc(LOCK + 6);
        expect_state(5, "R8");
        sleep_req = 0; cyc(2); stop_req = 0; cyc(SGX + 3);

        // R11: reset with stop request held
        cur_req = "R11";
        do_reset(1'b1, 1'b1);
        expect_state(2, "R11");
        cyc(5);
        stop_req = 0; cyc(SGX + 3);

        // R2: quick-start mode
        cur_req = "R2";
        do_reset(1'b0, 1'b0);
        stop_req = 1; grant_ack = 1; cyc(); pulse_clear(); cyc();
        expect_state(3, "R2");
        cur_req = "R6";
        snoop_begin = 1; cyc(); pulse_clear(); snoop_end = 1; cyc(); pulse_clear(); cyc();
        expect_state(3, "R6");
        cur_req = "R9";
        evt_in = 5'b11111; cyc(); pulse_clear(); cyc();
        cur_req = "R8";
        bclk_present = 0; cyc(5);
        bclk_present = 1; cyc(LOCK + 6);
        expect_state(3, "R8");
        cur_req = "R10";
        stop_req = 0; cyc(QSX + 4);
        expect_state(0, "R10");
        cur_req = "R11";
        do_reset(1'b0, 1'b1);
        expect_state(3, "R11");
        stop_req = 0; cyc(QSX + 3);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule